// File: doc/BRIEF.md
# LED Indication Conditioner with Per-Event Pulse Stretching

This block sits between the per-port status and activity signals of a switch and the path that shows them on indicator lamps. Signals that change rarely (forwarding of unknown destinations enabled, mirror-port configuration, duplex setting) pass straight to the outputs. Activity events last far too briefly to see: transmit enable, receive data valid, collision and receive buffer full. Each of these has its own retriggerable one-shot, which keeps the indication lit for a hold time chosen by the display mode.

The block also forms a port-health indication. It is active only when the port is enabled, the link check passes and the port is not partitioned. In display mode 0 the status output shows this health value directly. In display mode 1 the status output is health stretched by its own one-shot. A partition flag and a secondary-mode flag, which is the inverse of the mode select, are also driven.

Each one-shot is a two-state machine. IDLE goes to HOLD on an event, loading the hold count for the current mode (the "arm" transition). In HOLD, an event reloads the full count ("retrigger"). A timebase tick with no event decrements the count ("count down"). A tick that arrives with the count at 1 and no event returns the machine to IDLE ("release"). A synchronous reset forces IDLE from any state ("clear"). Hold times are counted in ticks of an external LED timebase. The defaults are 62000 ticks for mode 0 (about 62 ms at 1 MHz) and 1515 ticks for mode 1 (about 7.5 ms at 202 kHz).

Top module: `led_event_bank`

## Requirements
- R1: A stretched output (tx_act, rx_act, col_act, bfull_act) is high in every cycle its event input is high, with no added latency.
- R2: With mode_sel = 0 when the event was last seen, the output stays high for exactly HOLD_MODE0 ticks after the last cycle with the event high, then goes low.
- R3: With mode_sel = 1 when the event was last seen, the hold lasts exactly HOLD_MODE1 ticks.
- R4: An event during a hold reloads the full hold count, so the hold is measured from the most recent event.
- R5: The hold count decreases only on cycles with tick = 1. Without ticks, a held output stays high.
- R6: unk_fwd_act, sniffer_act and duplex_act equal unk_fwd_en, sniffer_cfg and full_duplex on every port, with no delay.
- R7: health_act is 1 exactly when port_en = 1, link_ok = 1 and partition = 0.
- R8: status_act equals health_act when mode_sel = 0. When mode_sel = 1 it is health stretched by the mode-1 hold.
- R9: secondary_mode is the inverse of mode_sel.
- R10: partition_act equals partition.
- R11: A synchronous reset (rst = 1 at a clock edge) returns every one-shot to IDLE, so each stretched output follows only its event input afterwards.
- R12: The hold length is fixed when the one-shot is armed or retriggered. A change of mode_sel during a hold does not change that hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Display mode: 0 long hold, 1 short hold |
| tick | input | 1 | One-cycle pulse of the LED timebase |
| port_en | input | NPORTS | Port enabled |
| link_ok | input | NPORTS | Link integrity check passing |
| partition | input | NPORTS | Port in partition state |
| tx_en | input | NPORTS | Transmit in progress |
| rx_dv | input | NPORTS | Receive data valid |
| col | input | NPORTS | Collision active |
| rxbuf_full | input | NPORTS | Receive buffer full |
| unk_fwd_en | input | NPORTS | Unknown-destination forwarding enabled |
| sniffer_cfg | input | NPORTS | Port configured as traffic mirror |
| full_duplex | input | NPORTS | Port in full duplex |
| tx_act | output | NPORTS | Stretched transmit indication |
| rx_act | output | NPORTS | Stretched receive indication |
| col_act | output | NPORTS | Stretched collision indication |
| bfull_act | output | NPORTS | Stretched buffer-full indication |
| status_act | output | NPORTS | Port status, direct or stretched by mode |
| health_act | output | NPORTS | Gated port-health indication |
| partition_act | output | NPORTS | Partition indication |
| unk_fwd_act | output | NPORTS | Forwarding indication, pass-through |
| sniffer_act | output | NPORTS | Mirror indication, pass-through |
| duplex_act | output | NPORTS | Duplex indication, pass-through |
| secondary_mode | output | 1 | Inverse of mode_sel |

## Verification
The assertions assume that both hold parameters are at least 1. They also assume that rst is high at the first clock edge, so that every one-shot starts in IDLE before any property that looks at past counts is enabled. The bench holds reset through its opening cycles and then applies all stimulus on the falling clock edge. It uses small hold parameters (20 and 6) so that every hold can be measured from start to end. Some scenarios change mode_sel or stop the ticks in the middle of a hold, and these changes also happen on the falling edge.

// File: rtl/led_event_pkg.sv
package led_event_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/led_stretcher.sv
module led_stretcher
    import led_event_pkg::*;
#(
    parameter int HOLD_A = 62000,
    parameter int HOLD_B = 1515
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic mode_sel,
    input  logic evt,
    output logic out_act
);
    localparam int HOLD_MAX = max_of(HOLD_A, HOLD_B);
    localparam int CW       = $clog2(HOLD_MAX + 1);
    localparam logic [CW-1:0] LOAD_A = CW'(HOLD_A);
    localparam logic [CW-1:0] LOAD_B = CW'(HOLD_B);
    localparam logic [CW-1:0] ONE    = CW'(1);

    hold_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] load_val;

    assign load_val = mode_sel ? LOAD_B : LOAD_A;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (evt) begin
                    state_d = ST_HOLD;
                    cnt_d   = load_val;
                end
            end
            ST_HOLD: begin
                if (evt) begin
                    cnt_d = load_val;
                end else if (tick) begin
                    if (cnt_q <= ONE) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        out_act = evt || (state_q == ST_HOLD);
    end

    assert_clear_R11: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE && cnt_q == '0));

    assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
        evt |=> (state_q == ST_HOLD &&
                 cnt_q == ($past(mode_sel) ? LOAD_B : LOAD_A)));

    assert_tick_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !evt && !tick) |=> $stable(cnt_q));

    assert_release_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && cnt_q == ONE && tick && !evt) |=> (state_q == ST_IDLE));

    assert_mode_free_R12: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && cnt_q > ONE && tick && !evt) |=> (cnt_q == $past(cnt_q) - ONE));

    assert_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(HOLD_MAX));
endmodule

// File: rtl/led_port_cond.sv
module led_port_cond #(
    parameter int HOLD_MODE0 = 62000,
    parameter int HOLD_MODE1 = 1515
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_sel,
    input  logic tick,
    input  logic port_en,
    input  logic link_ok,
    input  logic partition,
    input  logic tx_en,
    input  logic rx_dv,
    input  logic col,
    input  logic rxbuf_full,
    output logic tx_act,
    output logic rx_act,
    output logic col_act,
    output logic bfull_act,
    output logic status_act,
    output logic health_act
);
    localparam int NDYN = 4;

    logic [NDYN-1:0] dyn_in;
    logic [NDYN-1:0] dyn_out;
    logic            healthy;
    logic            status_evt;
    logic            status_held;

    assign dyn_in  = {rxbuf_full, col, rx_dv, tx_en};
    assign healthy = port_en && link_ok && !partition;

    for (genvar k = 0; k < NDYN; k++) begin : g_dyn
        led_stretcher #(.HOLD_A(HOLD_MODE0), .HOLD_B(HOLD_MODE1)) u_str (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .mode_sel(mode_sel),
            .evt     (dyn_in[k]),
            .out_act (dyn_out[k])
        );
    end

    assign status_evt = healthy && mode_sel;

    led_stretcher #(.HOLD_A(HOLD_MODE0), .HOLD_B(HOLD_MODE1)) u_status (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode_sel(mode_sel),
        .evt     (status_evt),
        .out_act (status_held)
    );

    assign tx_act     = dyn_out[0];
    assign rx_act     = dyn_out[1];
    assign col_act    = dyn_out[2];
    assign bfull_act  = dyn_out[3];
    assign health_act = healthy;
    assign status_act = mode_sel ? status_held : healthy;

    assert_evt_visible_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_en |-> tx_act) and (rx_dv |-> rx_act) and
        (col |-> col_act) and (rxbuf_full |-> bfull_act));

    assert_health_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (!port_en || !link_ok || partition) |-> !health_act);

    assert_status_mode_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && health_act) |-> status_act);
endmodule

// File: rtl/led_event_bank.sv
module led_event_bank #(
    parameter int NPORTS     = 4,
    parameter int HOLD_MODE0 = 62000,
    parameter int HOLD_MODE1 = 1515
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              tick,
    input  logic [NPORTS-1:0] port_en,
    input  logic [NPORTS-1:0] link_ok,
    input  logic [NPORTS-1:0] partition,
    input  logic [NPORTS-1:0] tx_en,
    input  logic [NPORTS-1:0] rx_dv,
    input  logic [NPORTS-1:0] col,
    input  logic [NPORTS-1:0] rxbuf_full,
    input  logic [NPORTS-1:0] unk_fwd_en,
    input  logic [NPORTS-1:0] sniffer_cfg,
    input  logic [NPORTS-1:0] full_duplex,
    output logic [NPORTS-1:0] tx_act,
    output logic [NPORTS-1:0] rx_act,
    output logic [NPORTS-1:0] col_act,
    output logic [NPORTS-1:0] bfull_act,
    output logic [NPORTS-1:0] status_act,
    output logic [NPORTS-1:0] health_act,
    output logic [NPORTS-1:0] partition_act,
    output logic [NPORTS-1:0] unk_fwd_act,
    output logic [NPORTS-1:0] sniffer_act,
    output logic [NPORTS-1:0] duplex_act,
    output logic              secondary_mode
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        led_port_cond #(.HOLD_MODE0(HOLD_MODE0), .HOLD_MODE1(HOLD_MODE1)) u_port (
            .clk       (clk),
            .rst       (rst),
            .mode_sel  (mode_sel),
            .tick      (tick),
            .port_en   (port_en[p]),
            .link_ok   (link_ok[p]),
            .partition (partition[p]),
            .tx_en     (tx_en[p]),
            .rx_dv     (rx_dv[p]),
            .col       (col[p]),
            .rxbuf_full(rxbuf_full[p]),
            .tx_act    (tx_act[p]),
            .rx_act    (rx_act[p]),
            .col_act   (col_act[p]),
            .bfull_act (bfull_act[p]),
            .status_act(status_act[p]),
            .health_act(health_act[p])
        );
    end

    assign partition_act  = partition;
    assign unk_fwd_act    = unk_fwd_en;
    assign sniffer_act    = sniffer_cfg;
    assign duplex_act     = full_duplex;
    assign secondary_mode = !mode_sel;

    assert_secondary_R9: assert property (@(posedge clk) disable iff (rst)
        secondary_mode != mode_sel);

    assert_partition_R10: assert property (@(posedge clk) disable iff (rst)
        partition_act == partition);
endmodule

// File: tb/led_event_bank_tb.sv
module led_event_bank_tb;
    localparam int NP = 2;
    localparam int H0 = 20;
    localparam int H1 = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b0;
    logic tick = 1'b1;
    logic [NP-1:0] port_en = '0, link_ok = '0, partition = '0;
    logic [NP-1:0] tx_en = '0, rx_dv = '0, col = '0, rxbuf_full = '0;
    logic [NP-1:0] unk_fwd_en = '0, sniffer_cfg = '0, full_duplex = '0;
    logic [NP-1:0] tx_act, rx_act, col_act, bfull_act, status_act, health_act;
    logic [NP-1:0] partition_act, unk_fwd_act, sniffer_act, duplex_act;
    logic secondary_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    led_event_bank #(.NPORTS(NP), .HOLD_MODE0(H0), .HOLD_MODE1(H1)) u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .tick(tick),
        .port_en(port_en), .link_ok(link_ok), .partition(partition),
        .tx_en(tx_en), .rx_dv(rx_dv), .col(col), .rxbuf_full(rxbuf_full),
        .unk_fwd_en(unk_fwd_en), .sniffer_cfg(sniffer_cfg), .full_duplex(full_duplex),
        .tx_act(tx_act), .rx_act(rx_act), .col_act(col_act), .bfull_act(bfull_act),
        .status_act(status_act), .health_act(health_act), .partition_act(partition_act),
        .unk_fwd_act(unk_fwd_act), .sniffer_act(sniffer_act), .duplex_act(duplex_act),
        .secondary_mode(secondary_mode)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic measure_tx(input int p, output int n);
        n = 0;
        while (tx_act[p] && n < 1000) begin
            n++;
            step();
        end
    endtask

    task automatic t_reset_state();
        check_eq("R11 reset tx_act", int'(tx_act), 0);
        check_eq("R11 reset status_act", int'(status_act), 0);
        check_eq("R9 secondary at mode 0", int'(secondary_mode), 1);
    endtask

    task automatic t_static();
        @(negedge clk);
        unk_fwd_en = 2'b01; sniffer_cfg = 2'b10; full_duplex = 2'b11; partition = 2'b10;
        #1;
        check_eq("R6 unk_fwd", int'(unk_fwd_act), 1);
        check_eq("R6 sniffer", int'(sniffer_act), 2);
        check_eq("R6 duplex", int'(duplex_act), 3);
        check_eq("R10 partition", int'(partition_act), 2);
        @(negedge clk);
        unk_fwd_en = 2'b10; sniffer_cfg = 2'b01; full_duplex = 2'b00; partition = 2'b00;
        #1;
        check_eq("R6 unk_fwd swap", int'(unk_fwd_act), 2);
        check_eq("R6 duplex clear", int'(duplex_act), 0);
        check_eq("R10 partition clear", int'(partition_act), 0);
    endtask

    task automatic t_health();
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            port_en[1] = v[0]; link_ok[1] = v[1]; partition[1] = v[2];
            #1;
            check_eq("R7 health gate", int'(health_act[1]), (v == 3) ? 1 : 0);
            check_eq("R8 status mode0 direct", int'(status_act[1]), (v == 3) ? 1 : 0);
        end
        @(negedge clk);
        port_en[1] = 1'b0; link_ok[1] = 1'b0; partition[1] = 1'b0;
    endtask

    task automatic t_secondary();
        @(negedge clk); mode_sel = 1'b1; #1;
        check_eq("R9 secondary at mode 1", int'(secondary_mode), 0);
        @(negedge clk); mode_sel = 1'b0; #1;
        check_eq("R9 secondary back", int'(secondary_mode), 1);
    endtask

    task automatic t_stretch(input logic m, input int exp);
        int n;
        @(negedge clk); mode_sel = m;
        @(negedge clk); tx_en[0] = 1'b1; #1;
        check_eq("R1 same-cycle visibility", int'(tx_act[0]), 1);
        @(negedge clk); tx_en[0] = 1'b0; #1;
        measure_tx(0, n);
        check_eq(m ? "R3 mode1 hold length" : "R2 mode0 hold length", n, exp);
        check_eq("R2 output low after hold", int'(tx_act[0]), 0);
    endtask

    task automatic t_other_events();
        @(negedge clk); mode_sel = 1'b1; rx_dv[1] = 1'b1; col[0] = 1'b1; rxbuf_full[1] = 1'b1; #1;
        check_eq("R1 rx col bfull visible", int'({rx_act[1], col_act[0], bfull_act[1]}), 7);
        @(negedge clk); rx_dv[1] = 1'b0; col[0] = 1'b0; rxbuf_full[1] = 1'b0;
        repeat (H1 - 1) step();
        check_eq("R3 rx still held", int'(rx_act[1]), 1);
        step();
        check_eq("R3 rx released", int'({rx_act[1], col_act[0], bfull_act[1]}), 0);
        @(negedge clk); mode_sel = 1'b0;
    endtask

    task automatic t_retrigger();
        int n;
        @(negedge clk); mode_sel = 1'b0; tx_en[1] = 1'b1;
        @(negedge clk); tx_en[1] = 1'b0;
        repeat (5) step();
        check_eq("R4 held before retrigger", int'(tx_act[1]), 1);
        @(negedge clk); tx_en[1] = 1'b1;
        @(negedge clk); tx_en[1] = 1'b0; #1;
        measure_tx(1, n);
        check_eq("R4 full reload on retrigger", n, H0);
    endtask

    task automatic t_tick_gate();
        int n;
        @(negedge clk); mode_sel = 1'b1; tx_en[0] = 1'b1;
        @(negedge clk); tx_en[0] = 1'b0; tick = 1'b0;
        repeat (50) step();
        check_eq("R5 held without ticks", int'(tx_act[0]), 1);
        @(negedge clk); tick = 1'b1; #1;
        measure_tx(0, n);
        check_eq("R5 countdown only on ticks", n, H1);
        @(negedge clk); mode_sel = 1'b0;
    endtask

    task automatic t_mode_change();
        int n;
        @(negedge clk); mode_sel = 1'b0; tx_en[0] = 1'b1;
        @(negedge clk); tx_en[0] = 1'b0; mode_sel = 1'b1; #1;
        measure_tx(0, n);
        check_eq("R12 hold fixed at arm", n, H0);
        @(negedge clk); mode_sel = 1'b0;
    endtask

    task automatic t_status_stretch();
        int n;
        @(negedge clk); mode_sel = 1'b1; port_en[0] = 1'b1; link_ok[0] = 1'b1;
        repeat (3) step();
        check_eq("R8 status mode1 active", int'(status_act[0]), 1);
        @(negedge clk); link_ok[0] = 1'b0; #1;
        check_eq("R7 health drops at once", int'(health_act[0]), 0);
        n = 0;
        while (status_act[0] && n < 1000) begin n++; step(); end
        check_eq("R8 status mode1 stretched", n, H1);
        @(negedge clk); mode_sel = 1'b0; link_ok[0] = 1'b1; #1;
        check_eq("R8 status mode0 follows health", int'(status_act[0]), 1);
        @(negedge clk); link_ok[0] = 1'b0; #1;
        check_eq("R8 status mode0 drops at once", int'(status_act[0]), 0);
        port_en[0] = 1'b0;
    endtask

    task automatic t_sync_reset();
        @(negedge clk); mode_sel = 1'b0; tx_en[1] = 1'b1; col[1] = 1'b1;
        @(negedge clk); tx_en[1] = 1'b0; col[1] = 1'b0;
        repeat (2) step();
        @(negedge clk); rst = 1'b1; #1;
        check_eq("R11 reset waits for edge", int'(tx_act[1]), 1);
        @(negedge clk); rst = 1'b0; #1;
        check_eq("R11 reset clears hold", int'({tx_act[1], col_act[1]}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset_state();
        @(negedge clk); rst = 1'b0;
        t_static();
        t_health();
        t_secondary();
        t_stretch(1'b0, H0);
        t_stretch(1'b1, H1);
        t_other_events();
        t_retrigger();
        t_tick_gate();
        t_mode_change();
        t_status_stretch();
        t_sync_reset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule